// File: doc/BRIEF.md
# Burst Capture and Readout Sequencer

This block drives an image sensor that keeps charge in a short storage register inside each pixel. The machine cycle has two parts: a short collision train, then a long quiet gap. During the train the sequencer makes a fixed number of transfers from the photogate into storage. It gives each transfer a gate pulse of programmable width. It follows each pulse with a one-cycle shift of the storage register. The transfers repeat at a programmable interval, which gives the slow capture rate.

The train ends once the last transfer interval is over. The sequencer then waits a programmable settling count. After that it runs the readout phase at a faster programmable tick. For every stored sample of every row, the readout does three things in order: it pulses the reset gate for one tick, selects the row for one tick while the column converters sample, and then advances the storage register for one tick. Conversion and readout never overlap the train. This keeps switching noise away from the beam.

A train-start trigger that arrives while a train is being captured, or during the final done cycle, raises a sticky error flag and changes nothing else. A trigger that arrives while the sequencer is still waiting or reading out ends that readout. It raises a sticky overrun flag and starts the new capture at once.

Top module: `burst_seq`

## Requirements
- R1: After a synchronous active-low reset the sequencer is idle. Every strobe, every status output and both sticky flags are low.
- R2: A trigger sampled while idle starts capture in the next cycle. Capture consists of NX transfer steps of `cfg_period` cycles each. `pg_xfer` is high for the first `cfg_width` cycles of every step, and `cap_busy` is high for all NX*`cfg_period` cycles.
- R3: In each capture step, `store_clk` is high for exactly one cycle: the cycle that follows the end of the transfer pulse, which is cycle `cfg_width` of the step.
- R4: `rst_gate`, `row_sel` and `sample` stay low during capture and during the quiet wait.
- R5: After capture there are exactly `cfg_quiet` cycles with no busy flag and no strobe. Readout starts in the cycle after them.
- R6: Readout visits rows 0 up to ROWS-1 in ascending order and DEPTH samples per row. Each sample uses three ticks of `cfg_rdiv` cycles, in this order: `rst_gate` high, then one-hot `row_sel` high (bit = row index), then `store_clk` high. `rd_busy` is high throughout.
- R7: `sample` is high for one cycle: the last cycle of each row-select tick.
- R8: In the cycle after the final readout tick, `done` is high for exactly one cycle. The sequencer is idle in the cycle after that.
- R9: A trigger sampled during capture or during the done cycle sets `err_trig` from the next cycle on, and has no other effect on any output. The flag stays set until reset.
- R10: A trigger sampled during the quiet wait or during readout stops that phase. From the next cycle on, `overrun` is set and a fresh capture runs as in R2. The flag stays set until reset.
- R11: At most one of `pg_xfer`, `store_clk`, `rst_gate` and any `row_sel` bit is high in any cycle, and `row_sel` is never more than one-hot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Train-start trigger, one cycle |
| cfg_period | input | CW | Cycles per capture transfer step |
| cfg_width | input | CW | Transfer pulse width in cycles |
| cfg_quiet | input | CW | Cycles of wait between capture and readout |
| cfg_rdiv | input | CW | Cycles per readout tick |
| pg_xfer | output | 1 | Photogate-to-storage transfer gate |
| store_clk | output | 1 | Storage register shift enable |
| rst_gate | output | 1 | Sense-node reset gate strobe |
| row_sel | output | ROWS | One-hot row select |
| sample | output | 1 | Column-parallel sample strobe |
| cap_busy | output | 1 | Capture phase active |
| rd_busy | output | 1 | Readout phase active |
| done | output | 1 | One-cycle end-of-readout pulse |
| err_trig | output | 1 | Sticky flag: trigger ignored |
| overrun | output | 1 | Sticky flag: readout aborted by a new train |

## Verification
The properties rely on the configuration holding still for a whole cycle. They also assume `cfg_width` is at least 1 and below `cfg_period`, and that `cfg_quiet` and `cfg_rdiv` are at least 1. If any of these fails, the transfer and shift strobes may overlap or a counter may never reach its end. The stimulus writes the configuration only on the falling edge before a trigger and keeps every value inside these bounds. It varies the period, width, wait and tick values from run to run. The extra triggers are placed at fixed cycle offsets in capture, in the done cycle, in the wait and in readout.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the burst sequencer.
// Assumes: nothing beyond an IEEE 1800-2017 compiler.
package burst_seq_pkg;

    // Phases of one machine cycle.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CAPTURE = 3'd1,
        ST_WAIT    = 3'd2,
        ST_READ    = 3'd3,
        ST_DONE    = 3'd4
    } seq_state_t;

    // Readout sub-phases within a single stored sample.
    localparam logic [1:0] PH_RESET = 2'd0;
    localparam logic [1:0] PH_ROW   = 2'd1;
    localparam logic [1:0] PH_SHIFT = 2'd2;

endpackage

// File: rtl/bsq_capture.sv
`timescale 1ns/1ps
// Capture engine. While en is high it runs NX transfer steps of cfg_period
// cycles each. In every step the transfer gate is high for cycles
// [0, cfg_width) and the storage shift is high in cycle cfg_width.
// Assumes: 1 <= cfg_width < cfg_period, with cfg stable while en is high.
// When en drops, the counters clear, so a new capture starts at step 0.
module bsq_capture #(
    parameter int NX = 20,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_width,
    output logic          pg_xfer,
    output logic          shift,
    output logic          cap_done
);
    localparam int XW = (NX > 1) ? $clog2(NX) : 1;

    logic [CW-1:0] step_cyc;
    logic [XW-1:0] step_idx;
    logic          step_last;
    logic          idx_last;

    assign step_last = (step_cyc == cfg_period - CW'(1));
    assign idx_last  = (step_idx == XW'(NX - 1));

    // Purpose: count the cycle position inside the current transfer step.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  step_cyc <= '0;
        else if (step_last) step_cyc <= '0;
        else                step_cyc <= step_cyc + CW'(1);
    end

    // Purpose: count completed transfer steps within the train.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) step_idx <= '0;
        else if (step_last) step_idx <= idx_last ? '0 : step_idx + XW'(1);
    end

    // Purpose: decode gate, shift and end-of-capture from the counters.
    always_comb begin
        pg_xfer  = en && (step_cyc < cfg_width);
        shift    = en && (step_cyc == cfg_width);
        cap_done = en && step_last && idx_last;
    end

endmodule

// File: rtl/bsq_readout.sv
`timescale 1ns/1ps
// Readout engine. While en is high it walks ROWS rows x DEPTH samples.
// Each sample takes three ticks of cfg_rdiv cycles: reset gate, row select
// (with a sample strobe in the tick's last cycle), then storage shift.
// Assumes: cfg_rdiv >= 1, stable while en is high. The counters clear when
// en drops, which makes abort and restart free.
module bsq_readout
    import burst_seq_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int DEPTH = 20,
    parameter int CW    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [CW-1:0]   cfg_rdiv,
    output logic            rst_gate,
    output logic [ROWS-1:0] row_sel,
    output logic            sample,
    output logic            shift,
    output logic            rd_done
);
    localparam int RW = (ROWS  > 1) ? $clog2(ROWS)  : 1;
    localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0] tick_cyc;
    logic [1:0]    phase;
    logic [SW-1:0] smp_idx;
    logic [RW-1:0] row_idx;
    logic          tick_end, phase_end, smp_end, row_end;

    assign tick_end  = (tick_cyc == cfg_rdiv - CW'(1));
    assign phase_end = (phase == PH_SHIFT);
    assign smp_end   = (smp_idx == SW'(DEPTH - 1));
    assign row_end   = (row_idx == RW'(ROWS - 1));

    // Purpose: divide the system clock down to the readout tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) tick_cyc <= '0;
        else if (tick_end) tick_cyc <= '0;
        else               tick_cyc <= tick_cyc + CW'(1);
    end

    // Purpose: step reset -> row -> shift once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) phase <= PH_RESET;
        else if (tick_end) phase <= phase_end ? PH_RESET : phase + 2'd1;
    end

    // Purpose: count samples within the current row.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) smp_idx <= '0;
        else if (tick_end && phase_end) smp_idx <= smp_end ? '0 : smp_idx + SW'(1);
    end

    // Purpose: advance to the next row after its last sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) row_idx <= '0;
        else if (tick_end && phase_end && smp_end) row_idx <= row_end ? '0 : row_idx + RW'(1);
    end

    // Purpose: decode one select line per row.
    for (genvar g = 0; g < ROWS; g++) begin : g_row
        assign row_sel[g] = en && (phase == PH_ROW) && (row_idx == RW'(g));
    end

    // Purpose: decode the per-sample strobes and end of readout.
    always_comb begin
        rst_gate = en && (phase == PH_RESET);
        shift    = en && phase_end;
        sample   = en && (phase == PH_ROW) && tick_end;
        rd_done  = en && tick_end && phase_end && smp_end && row_end;
    end

endmodule

// File: rtl/burst_seq.sv
`timescale 1ns/1ps
// Top of the burst capture and readout sequencer. Holds the phase state
// machine, the quiet-wait timer and the sticky flags. It enables the capture
// engine only in CAPTURE and the readout engine only in READ, and merges the
// two storage shift strobes into one output.
// Assumes: trig is synchronous to clk; cfg is valid as listed in the brief.
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int NX    = 20,
    parameter int DEPTH = 20,
    parameter int ROWS  = 4,
    parameter int CW    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig,
    input  logic [CW-1:0]   cfg_period,
    input  logic [CW-1:0]   cfg_width,
    input  logic [CW-1:0]   cfg_quiet,
    input  logic [CW-1:0]   cfg_rdiv,
    output logic            pg_xfer,
    output logic            store_clk,
    output logic            rst_gate,
    output logic [ROWS-1:0] row_sel,
    output logic            sample,
    output logic            cap_busy,
    output logic            rd_busy,
    output logic            done,
    output logic            err_trig,
    output logic            overrun
);
    seq_state_t    state, state_nx;
    logic [CW-1:0] quiet_cyc;
    logic          quiet_end;
    logic          cap_shift, rd_shift, cap_done, rd_done;
    logic          in_cap, in_wait, in_read;
    logic          set_err, set_ovr;

    assign in_cap    = (state == ST_CAPTURE);
    assign in_wait   = (state == ST_WAIT);
    assign in_read   = (state == ST_READ);
    assign quiet_end = in_wait && (quiet_cyc == cfg_quiet - CW'(1));

    // Purpose: choose the next phase; an abort trigger beats any normal exit.
    always_comb begin
        state_nx = state;
        set_err  = 1'b0;
        set_ovr  = 1'b0;
        unique case (state)
            ST_IDLE:    if (trig) state_nx = ST_CAPTURE;
            ST_CAPTURE: begin
                set_err = trig;
                if (cap_done) state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (trig) begin
                    set_ovr  = 1'b1;
                    state_nx = ST_CAPTURE;
                end else if (quiet_end) begin
                    state_nx = ST_READ;
                end
            end
            ST_READ: begin
                if (trig) begin
                    set_ovr  = 1'b1;
                    state_nx = ST_CAPTURE;
                end else if (rd_done) begin
                    state_nx = ST_DONE;
                end
            end
            ST_DONE: begin
                set_err  = trig;
                state_nx = ST_IDLE;
            end
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Purpose: phase state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Purpose: time the quiet gap between capture and readout.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_wait) quiet_cyc <= '0;
        else                    quiet_cyc <= quiet_cyc + CW'(1);
    end

    // Purpose: sticky flags for ignored and aborting triggers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_trig <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (set_err) err_trig <= 1'b1;
            if (set_ovr) overrun  <= 1'b1;
        end
    end

    bsq_capture #(.NX(NX), .CW(CW)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (in_cap),
        .cfg_period (cfg_period),
        .cfg_width  (cfg_width),
        .pg_xfer    (pg_xfer),
        .shift      (cap_shift),
        .cap_done   (cap_done)
    );

    bsq_readout #(.ROWS(ROWS), .DEPTH(DEPTH), .CW(CW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (in_read),
        .cfg_rdiv (cfg_rdiv),
        .rst_gate (rst_gate),
        .row_sel  (row_sel),
        .sample   (sample),
        .shift    (rd_shift),
        .rd_done  (rd_done)
    );

    // Purpose: status and merged storage clock.
    always_comb begin
        store_clk = cap_shift | rd_shift;
        cap_busy  = in_cap;
        rd_busy   = in_read;
        done      = (state == ST_DONE);
    end

endmodule

// File: rtl/bsq_chk.sv
`timescale 1ns/1ps
// Property checker for burst_seq, attached through bind.
// Assumes: the configuration limits given in the brief.
module bsq_chk #(
    parameter int ROWS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trig,
    input logic            pg_xfer,
    input logic            store_clk,
    input logic            rst_gate,
    input logic [ROWS-1:0] row_sel,
    input logic            sample,
    input logic            cap_busy,
    input logic            rd_busy,
    input logic            done,
    input logic            err_trig,
    input logic            overrun
);
    // R11
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pg_xfer, store_clk, rst_gate, |row_sel}) <= 1);

    // R4
    quiet_in_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_busy |-> (!rst_gate && (row_sel == '0) && !sample));

    // R2
    xfer_in_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_xfer |-> cap_busy);

    // R7
    sample_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (rd_busy && (row_sel != '0)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !cap_busy && !rd_busy));

    // R8
    done_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rd_busy));

    // R9
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_busy && trig) |=> err_trig);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_trig |=> err_trig);

    // R10
    ovr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && trig) |=> (cap_busy && overrun));

    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind burst_seq bsq_chk #(.ROWS(ROWS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .pg_xfer   (pg_xfer),
    .store_clk (store_clk),
    .rst_gate  (rst_gate),
    .row_sel   (row_sel),
    .sample    (sample),
    .cap_busy  (cap_busy),
    .rd_busy   (rd_busy),
    .done      (done),
    .err_trig  (err_trig),
    .overrun   (overrun)
);

// File: tb/sim_burst_seq.sv
`timescale 1ns/1ps
// Scoreboard bench. The driver computes the expected output vector for every
// cycle from the requirements and queues it. The monitor compares each queued
// vector on the falling edge.
module sim_burst_seq;
    localparam int NX    = 20;
    localparam int DEPTH = 20;
    localparam int ROWS  = 4;
    localparam int CW    = 16;
    localparam int VW    = ROWS + 9;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            trig;
    logic [CW-1:0]   cfg_period, cfg_width, cfg_quiet, cfg_rdiv;
    logic            pg_xfer, store_clk, rst_gate, sample;
    logic [ROWS-1:0] row_sel;
    logic            cap_busy, rd_busy, done, err_trig, overrun;
    logic [VW-1:0]   act;

    logic [VW-1:0]   exp_q[$];
    string           tag_q[$];
    int              n_cmp = 0;
    int              n_bad = 0;
    bit              g_err = 1'b0;
    bit              g_ovr = 1'b0;
    logic [VW-1:0]   mon_exp;
    string           mon_tag;

    always #2 clk = ~clk;

    burst_seq #(.NX(NX), .DEPTH(DEPTH), .ROWS(ROWS), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .trig(trig),
        .cfg_period(cfg_period), .cfg_width(cfg_width),
        .cfg_quiet(cfg_quiet), .cfg_rdiv(cfg_rdiv),
        .pg_xfer(pg_xfer), .store_clk(store_clk), .rst_gate(rst_gate),
        .row_sel(row_sel), .sample(sample), .cap_busy(cap_busy),
        .rd_busy(rd_busy), .done(done), .err_trig(err_trig), .overrun(overrun)
    );

    assign act = {overrun, err_trig, done, rd_busy, cap_busy, sample,
                  rst_gate, store_clk, pg_xfer, row_sel};

    // Expected outputs in cycle i after the starting trigger edge.
    function automatic void model(input int i, input int p, input int w,
                                  input int q, input int d, input bit e,
                                  input bit o, output logic [VW-1:0] v,
                                  output string tg);
        int lc = NX * p;
        int lr = ROWS * DEPTH * 3 * d;
        logic pg = 0, sc = 0, rg = 0, sm = 0, cb = 0, rb = 0, dn = 0;
        logic [ROWS-1:0] rs = '0;
        tg = "R1 idle";
        if (i < lc) begin
            cb = 1; pg = (i % p) < w; sc = (i % p) == w;
            tg = "R2 R3 capture";
        end else if (i < lc + q) begin
            tg = "R4 R5 wait";
        end else if (i < lc + q + lr) begin
            int t   = i - lc - q;
            int tk  = t / d;
            int ph  = tk % 3;
            int row = (tk / 3) / DEPTH;
            rb = 1; rg = (ph == 0); sc = (ph == 2);
            if (ph == 1) rs[row] = 1'b1;
            sm = (ph == 1) && ((t % d) == d - 1);
            tg = "R6 R7 readout";
        end else if (i == lc + q + lr) begin
            dn = 1; tg = "R8 done";
        end
        v = {o, e, dn, rb, cb, sm, rg, sc, pg, rs};
    endfunction

    task automatic push_range(input int from, input int to, input int p,
                              input int w, input int q, input int d,
                              input int err_after, input bit e0, input bit o,
                              input string pre);
        for (int i = from; i <= to; i++) begin
            logic [VW-1:0] v;
            string tg;
            bit e = e0 || (err_after >= 0 && i > err_after);
            model(i, p, w, q, d, e, o, v, tg);
            if (err_after >= 0 && i > err_after) tg = {"R9 ", tg};
            exp_q.push_back(v);
            tag_q.push_back({pre, tg});
        end
    endtask

    // Driver: start a train; optionally fire a second trigger at cycle index.
    task automatic run_seq(input int p, input int w, input int q, input int d,
                           input int err_at, input int ovr_at);
        int last = NX * p + q + ROWS * DEPTH * 3 * d;
        int extra = (ovr_at >= 0) ? ovr_at : err_at;
        @(negedge clk);
        cfg_period = CW'(p); cfg_width = CW'(w);
        cfg_quiet  = CW'(q); cfg_rdiv  = CW'(d);
        trig = 1'b1;
        @(posedge clk); #1 trig = 1'b0;
        if (ovr_at >= 0) begin
            push_range(0, ovr_at, p, w, q, d, -1, g_err, g_ovr, "");
            g_ovr = 1'b1;
            push_range(0, last + 2, p, w, q, d, -1, g_err, 1'b1, "R10 ");
        end else begin
            push_range(0, last + 2, p, w, q, d, err_at, g_err, g_ovr, "");
            if (err_at >= 0) g_err = 1'b1;
        end
        if (extra >= 0) begin
            repeat (extra + 1) @(negedge clk);
            trig = 1'b1;
            @(posedge clk); #1 trig = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pop and compare one expected vector per cycle.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            mon_exp = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            n_cmp++;
            if (act !== mon_exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", mon_tag, act, mon_exp);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R8 watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; trig = 1'b0;
        cfg_period = CW'(6); cfg_width = CW'(2);
        cfg_quiet  = CW'(5); cfg_rdiv  = CW'(2);
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;
        if (act !== '0) begin
            n_bad++;
            $display("FAIL R1 reset: actual %h expected %h", act, {VW{1'b0}});
        end
        run_seq(6, 2, 5, 2, -1, -1);             // R2 R3 R5 R6 R7 R8
        run_seq(5, 1, 1, 1, -1, -1);             // R5 shortest wait, R6 fast tick
        run_seq(4, 3, 3, 3, -1, -1);             // R3 shift in last step cycle
        run_seq(6, 2, 4, 1, 37, -1);             // R9 trigger mid-capture
        run_seq(5, 2, 2, 1, 5*NX + 2 + ROWS*DEPTH*3, -1); // R9 trigger on done
        run_seq(5, 2, 3, 2, -1, 150);            // R10 abort during readout
        run_seq(5, 2, 6, 1, -1, 102);            // R10 abort during wait
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule